// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block resolves read-after-write hazards in a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access and writeback. It holds the tags of the instructions in flight: valid bit, destination register, write enable and a load flag. These tags sit in the decode/execute, execute/memory and memory/writeback pipeline registers. The block also holds the data captured at each of those boundaries.

For each execute-stage source operand, a three-way mux picks its value. The sources are the value read from the register file in decode, the execute/memory result and the memory/writeback result. When more than one in-flight producer writes the same register, the nearest one wins.

A load's data only exists at the end of the memory stage, so it cannot feed the instruction directly behind it. In that case the block raises `stall` to freeze fetch and decode for one cycle and puts a no-op into the decode/execute register.

The ALU, the data memory and the register file are outside the block. The ALU result returns on `alu_y` and the load data on `dmem_rdata`. The register file writes before it reads within a cycle, so a producer that is in writeback while its consumer is in decode needs no bypass.

Top module: `hazard_fwd_unit`

## Requirements
- R1: During and straight after synchronous reset, `wb_we` and `stall` are low.
- R2: A consumer directly behind a non-load producer receives the producer's result on its operand through the execute/memory path.
- R3: A consumer two instructions behind a producer, including a load, receives the result through the memory/writeback path, with no stall.
- R4: When both later pipeline registers hold valid writers of the same source register, the execute/memory (youngest) result is used.
- R5: Register 0 is never a bypass source: an operand naming register 0 always takes the register-file value, even when an in-flight instruction targets register 0.
- R6: A producer whose write enable is low, or whose valid bit is low, is never forwarded.
- R7: A valid decode instruction that reads (as either source) the non-zero destination of a valid writing load in execute raises `stall` for exactly one cycle. A no-op then enters execute, and the consumer later receives the loaded data.
- R8: A load whose destination is register 0, or one followed by an instruction that does not read its destination, causes no stall.
- R9: Writebacks appear on `wb_we`/`wb_rd`/`wb_data` in program order, one per valid writing instruction, and never for a bubble. The value written for an arithmetic instruction is `alu_y`, and for a load it is `dmem_rdata` sampled while the load is in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | RW | First source register of the decode instruction |
| id_rs2 | input | RW | Second source register of the decode instruction |
| id_rd | input | RW | Destination register of the decode instruction |
| id_wr | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_rf1 | input | DW | Register-file value for `id_rs1` |
| id_rf2 | input | DW | Register-file value for `id_rs2` |
| alu_y | input | DW | ALU result for the execute instruction |
| dmem_rdata | input | DW | Data memory read value for the memory-stage load |
| stall | output | 1 | Freeze fetch and decode this cycle |
| alu_a | output | DW | First execute operand after bypass |
| alu_b | output | DW | Second execute operand after bypass |
| mem_addr | output | DW | Execute/memory result, used as the load address |
| mem_load | output | 1 | A valid load is in the memory stage |
| wb_we | output | 1 | Register-file write strobe |
| wb_rd | output | RW | Register-file write address |
| wb_data | output | DW | Register-file write data |

## Verification
Each program is checked against a sequential reference model that runs it instruction by instruction. Producer/consumer distances of one, two and three tell the execute/memory path, the memory/writeback path and register-file write-through apart. A register written twice in a row separates youngest-first priority from oldest-first priority. Writers to register 0, non-writing instructions and invalid slots that carry a matching destination show whether any bypass ignores the valid bit, the write enable or the zero register. Loads followed by a dependent, an independent instruction, or a register-0 consumer tell a correct one-cycle interlock apart from a missing, spurious or overlong stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_EM = 2'd1,
    FWD_MW = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0]     src,
  input  logic [DW-1:0]     rf_val,
  input  logic              em_en,
  input  logic [RW-1:0]     em_rd,
  input  logic [DW-1:0]     em_val,
  input  logic              mw_en,
  input  logic [RW-1:0]     mw_rd,
  input  logic [DW-1:0]     mw_val,
  output hzd_pkg::fwd_sel_e sel,
  output logic [DW-1:0]     val
);
  import hzd_pkg::*;

  logic src_nz;
  logic em_hit;
  logic mw_hit;

  assign src_nz = (src != '0);
  assign em_hit = em_en && src_nz && (em_rd == src);
  assign mw_hit = mw_en && src_nz && (mw_rd == src);

  // nearest producer first
  always_comb begin
    if (em_hit) begin
      sel = FWD_EM;
      val = em_val;
    end else if (mw_hit) begin
      sel = FWD_MW;
      val = mw_val;
    end else begin
      sel = FWD_RF;
      val = rf_val;
    end
  end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int RW = 5
) (
  input  logic          id_valid,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          ex_valid,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] ex_rd,
  output logic          stall
);
  logic ex_pending;
  logic uses_rd;

  assign ex_pending = ex_valid && ex_wr && ex_load && (ex_rd != '0);
  assign uses_rd    = (id_rs1 == ex_rd) || (id_rs2 == ex_rd);
  assign stall      = id_valid && ex_pending && uses_rd;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] id_rd,
  input  logic          id_wr,
  input  logic          id_load,
  input  logic [DW-1:0] id_rf1,
  input  logic [DW-1:0] id_rf2,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] dmem_rdata,
  output logic          stall,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  output logic [DW-1:0] mem_addr,
  output logic          mem_load,
  output logic          wb_we,
  output logic [RW-1:0] wb_rd,
  output logic [DW-1:0] wb_data
);
  import hzd_pkg::*;

  localparam int NSRC = 2;

  logic [RW-1:0] id_rs [NSRC];
  logic [DW-1:0] id_rf [NSRC];

  assign id_rs[0] = id_rs1;
  assign id_rs[1] = id_rs2;
  assign id_rf[0] = id_rf1;
  assign id_rf[1] = id_rf2;

  // decode/execute register
  logic          ie_valid, ie_wr, ie_load;
  logic [RW-1:0] ie_rd;
  logic [RW-1:0] ie_rs [NSRC];
  logic [DW-1:0] ie_rf [NSRC];

  // execute/memory register
  logic          em_valid, em_wr, em_load;
  logic [RW-1:0] em_rd;
  logic [DW-1:0] em_val;

  // memory/writeback register
  logic          mw_valid, mw_wr;
  logic [RW-1:0] mw_rd;
  logic [DW-1:0] mw_val;

  fwd_sel_e      sel_v [NSRC];
  logic [DW-1:0] op_v  [NSRC];

  hzd_loaduse #(.RW(RW)) u_lu (
    .id_valid (id_valid),
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .ex_valid (ie_valid),
    .ex_wr    (ie_wr),
    .ex_load  (ie_load),
    .ex_rd    (ie_rd),
    .stall    (stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_valid <= 1'b0;
      ie_wr    <= 1'b0;
      ie_load  <= 1'b0;
      ie_rd    <= '0;
      for (int k = 0; k < NSRC; k++) begin
        ie_rs[k] <= '0;
        ie_rf[k] <= '0;
      end
    end else if (stall) begin
      // no-op into execute while decode is held
      ie_valid <= 1'b0;
      ie_wr    <= 1'b0;
      ie_load  <= 1'b0;
    end else begin
      ie_valid <= id_valid;
      ie_wr    <= id_wr;
      ie_load  <= id_load;
      ie_rd    <= id_rd;
      for (int k = 0; k < NSRC; k++) begin
        ie_rs[k] <= id_rs[k];
        ie_rf[k] <= id_rf[k];
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_fwd_sel #(.RW(RW), .DW(DW)) u_sel (
      .src    (ie_rs[g]),
      .rf_val (ie_rf[g]),
      .em_en  (em_valid && em_wr),
      .em_rd  (em_rd),
      .em_val (em_val),
      .mw_en  (mw_valid && mw_wr),
      .mw_rd  (mw_rd),
      .mw_val (mw_val),
      .sel    (sel_v[g]),
      .val    (op_v[g])
    );
  end

  assign alu_a = op_v[0];
  assign alu_b = op_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      em_valid <= 1'b0;
      em_wr    <= 1'b0;
      em_load  <= 1'b0;
      em_rd    <= '0;
      em_val   <= '0;
      mw_valid <= 1'b0;
      mw_wr    <= 1'b0;
      mw_rd    <= '0;
      mw_val   <= '0;
    end else begin
      em_valid <= ie_valid;
      em_wr    <= ie_wr;
      em_load  <= ie_load;
      em_rd    <= ie_rd;
      em_val   <= alu_y;
      mw_valid <= em_valid;
      mw_wr    <= em_wr;
      mw_rd    <= em_rd;
      mw_val   <= em_load ? dmem_rdata : em_val;
    end
  end

  assign mem_addr = em_val;
  assign mem_load = em_valid && em_load;
  assign wb_we    = mw_valid && mw_wr;
  assign wb_rd    = mw_rd;
  assign wb_data  = mw_val;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int RW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              ie_valid,
  input logic              ie_wr,
  input logic              ie_load,
  input logic [RW-1:0]     ie_rd,
  input logic [RW-1:0]     ie_rs0,
  input logic [RW-1:0]     ie_rs1,
  input hzd_pkg::fwd_sel_e sel0,
  input hzd_pkg::fwd_sel_e sel1,
  input logic              em_valid,
  input logic              em_wr,
  input logic              em_load,
  input logic              wb_we
);
  import hzd_pkg::*;

  a_r7_stall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  a_r7_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ie_valid);

  a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ie_valid && ie_wr && ie_load && (ie_rd != '0)));

  a_r7_no_load_bypass: assert property (@(posedge clk) disable iff (rst)
    ((sel0 == FWD_EM) || (sel1 == FWD_EM)) |-> !em_load);

  a_r5_no_r0_src_a: assert property (@(posedge clk) disable iff (rst)
    (sel0 != FWD_RF) |-> (ie_rs0 != '0));

  a_r5_no_r0_src_b: assert property (@(posedge clk) disable iff (rst)
    (sel1 != FWD_RF) |-> (ie_rs1 != '0));

  a_r6_em_needs_writer: assert property (@(posedge clk) disable iff (rst)
    ((sel0 == FWD_EM) || (sel1 == FWD_EM)) |-> (em_valid && em_wr));

  a_r9_wb_from_mem: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> $past(em_valid && em_wr));
endmodule

bind hazard_fwd_unit hzd_checker #(.RW(RW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .ie_valid (ie_valid),
  .ie_wr    (ie_wr),
  .ie_load  (ie_load),
  .ie_rd    (ie_rd),
  .ie_rs0   (ie_rs[0]),
  .ie_rs1   (ie_rs[1]),
  .sel0     (sel_v[0]),
  .sel1     (sel_v[1]),
  .em_valid (em_valid),
  .em_wr    (em_wr),
  .em_load  (em_load),
  .wb_we    (wb_we)
);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam logic [DW-1:0] LDK = 32'h5A5A_0F0F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          id_valid = 1'b0, id_wr = 1'b0, id_load = 1'b0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic [DW-1:0] id_rf1, id_rf2, alu_y, dmem_rdata;
  logic          stall, mem_load, wb_we;
  logic [DW-1:0] alu_a, alu_b, mem_addr, wb_data;
  logic [RW-1:0] wb_rd;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] regs [32];
  logic [DW-1:0] gold [32];
  logic [63:0]   exp_q [$];
  string         tag_q [$];

  // previous issued instruction, for the expected interlock
  logic          p_v = 1'b0, p_wr = 1'b0, p_ld = 1'b0;
  logic [RW-1:0] p_rd = '0;

  always #5 clk = ~clk;

  hazard_fwd_unit #(.RW(RW), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .id_wr(id_wr), .id_load(id_load), .id_rf1(id_rf1), .id_rf2(id_rf2),
    .alu_y(alu_y), .dmem_rdata(dmem_rdata),
    .stall(stall), .alu_a(alu_a), .alu_b(alu_b),
    .mem_addr(mem_addr), .mem_load(mem_load),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  // stubs: ALU adds, data memory scrambles the address, register file writes through
  assign alu_y      = alu_a + alu_b;
  assign dmem_rdata = mem_addr ^ LDK;
  assign id_rf1 = (id_rs1 == '0) ? '0 :
                  (wb_we && wb_rd == id_rs1) ? wb_data : regs[id_rs1];
  assign id_rf2 = (id_rs2 == '0) ? '0 :
                  (wb_we && wb_rd == id_rs2) ? wb_data : regs[id_rs2];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= (i == 0) ? '0 : DW'(i * 17 + 3);
    end else if (wb_we && wb_rd != '0) begin
      regs[wb_rd] <= wb_data;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each writeback
  always @(negedge clk) begin
    if (!rst && wb_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected writeback", {27'd0, wb_rd, wb_data}, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({27'd0, wb_rd, wb_data} == e, t, "writeback rd/data",
              {27'd0, wb_rd, wb_data}, e);
      end
    end
  end

  // driver: issue one instruction in decode, hold it while stalled
  task automatic issue(input string tag, input bit v, input bit wr, input bit ld,
                       input int rd, input int rs1, input int rs2);
    int exp_st;
    int got_st;
    logic [DW-1:0] res;
    exp_st = (p_v && p_wr && p_ld && p_rd != '0 && v &&
              (RW'(rs1) == p_rd || RW'(rs2) == p_rd)) ? 1 : 0;
    id_valid = v; id_wr = wr; id_load = ld;
    id_rd = RW'(rd); id_rs1 = RW'(rs1); id_rs2 = RW'(rs2);
    if (v && wr) begin
      res = gold[rs1] + gold[rs2];
      if (ld) res = res ^ LDK;
      exp_q.push_back({27'd0, RW'(rd), res});
      tag_q.push_back(tag);
      if (rd != 0) gold[rd] = res;
    end
    p_v = v; p_wr = wr; p_ld = ld; p_rd = RW'(rd);
    got_st = 0;
    #1;
    while (stall) begin
      got_st++;
      @(negedge clk);
      #1;
      if (got_st > 4) break;
    end
    if (v) check(got_st == exp_st, (ld || exp_st != 0) ? "R7/R8" : tag,
                 "stall cycles", 64'(got_st), 64'(exp_st));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue("R9", 1'b0, 1'b1, 1'b0, 17, 0, 0);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) gold[i] = (i == 0) ? '0 : DW'(i * 17 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!wb_we && !stall, "R1", "outputs in reset", {62'd0, wb_we, stall}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!wb_we && !stall, "R1", "outputs after reset", {62'd0, wb_we, stall}, 64'd0);

    // R2: distance one
    issue("R2", 1, 1, 0, 1, 2, 3);
    issue("R2", 1, 1, 0, 4, 1, 5);
    issue("R2", 1, 1, 0, 5, 6, 4);
    // R3: distance two and three
    issue("R3", 1, 1, 0, 6, 2, 3);
    issue("R3", 1, 1, 0, 7, 8, 9);
    issue("R3", 1, 1, 0, 10, 6, 6);
    issue("R3", 1, 1, 0, 8, 6, 7);
    // R4: same destination twice in a row
    issue("R4", 1, 1, 0, 11, 2, 3);
    issue("R4", 1, 1, 0, 11, 4, 5);
    issue("R4", 1, 1, 0, 12, 11, 11);
    // R5: writers to register 0
    issue("R5", 1, 1, 0, 0, 3, 4);
    issue("R5", 1, 1, 0, 13, 0, 0);
    issue("R5", 1, 1, 0, 0, 5, 6);
    issue("R5", 1, 1, 0, 9, 7, 7);
    issue("R5", 1, 1, 0, 14, 0, 2);
    // R6: non-writer and invalid slot with matching destinations
    issue("R6", 1, 0, 0, 15, 1, 2);
    issue("R6", 1, 1, 0, 16, 15, 2);
    issue("R6", 0, 1, 0, 17, 1, 1);
    issue("R6", 1, 1, 0, 18, 17, 1);
    // R7: load-use on either source, chained loads
    issue("R7", 1, 1, 1, 19, 2, 3);
    issue("R7", 1, 1, 0, 20, 19, 1);
    issue("R7", 1, 1, 1, 21, 4, 5);
    issue("R7", 1, 1, 0, 22, 1, 21);
    issue("R7", 1, 1, 1, 27, 2, 3);
    issue("R7", 1, 1, 1, 28, 27, 0);
    issue("R7", 1, 1, 0, 29, 28, 28);
    // R8: no stall cases
    issue("R8", 1, 1, 1, 23, 6, 7);
    issue("R8", 1, 1, 0, 24, 1, 2);
    issue("R8", 1, 1, 0, 25, 23, 23);
    issue("R8", 1, 1, 1, 0, 8, 9);
    issue("R8", 1, 1, 0, 26, 0, 1);
    issue("R8", 1, 0, 1, 30, 2, 2);
    issue("R8", 1, 1, 0, 31, 30, 30);
    // drain
    idle(6);
    check(exp_q.size() == 0, "R9", "writebacks outstanding",
          64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule